// File: doc/BRIEF.md
# Two-Sector Instruction Cache

This block sits between an instruction fetch unit and a slower program memory. It holds two sectors. Each sector covers one aligned region of `WORDS` instruction words and keeps a valid bit for every word. A fetch that finds its word valid in a sector is answered in the same cycle, without a stall. Any other fetch goes to memory over a request/acknowledge read port whose latency can vary.

A miss whose region is already held by a sector loads only the missing word into that sector. A miss whose region is held by neither sector takes over the least recently used sector. That sector gets the new region tag, all of its valid bits are cleared, and the fetched word is then loaded into it.

Two global controls shape the behaviour. With freeze active, the cache keeps its contents and its replacement order fixed, and misses are still served from memory. With enable low, every fetch bypasses the cache, and the stored contents are kept for later use.

Top module: `isc_cache`

## Requirements
- R1: After reset no sector holds a region. The first fetch of any address misses, and while no fetch is requested neither `fetch_stall` nor `mem_req` is high.
- R2: A fetch whose word is valid in a sector returns the stored word on `fetch_data` in the same cycle, with `fetch_stall` and `mem_req` both low.
- R3: On a miss, `mem_req` is high with `mem_addr` equal to `fetch_addr`, and `fetch_stall` stays high until `mem_ack`. In the `mem_ack` cycle `fetch_stall` is low and `fetch_data` equals `mem_rdata`.
- R4: A miss inside a region that a sector already holds loads only that word. Words loaded earlier still hit, and words never loaded still miss.
- R5: A miss outside both held regions reallocates one sector to the new region, with tag = address >> log2(WORDS), and clears all of its valid bits except the loaded word. An address with the same word index as an old word of that sector misses.
- R6: The replacement choice starts at sector 0. Every hit and every fill, when not frozen, sets it to the sector not used by that access, so the least recently used sector is the one evicted.
- R7: While `cfg_freeze` is high (and `cfg_enable` high), hits are served, misses are served from memory without loading or allocating anything, and the replacement choice does not change.
- R8: While `cfg_enable` is low, every fetch goes to memory and returns `mem_rdata`, even for a cached word. Nothing is loaded, and after re-enable the earlier contents hit again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_enable | input | 1 | Cache on; low bypasses every fetch |
| cfg_freeze | input | 1 | Hold contents and replacement order |
| fetch_req | input | 1 | Fetch request, held until not stalled |
| fetch_addr | input | ADDR_W | Word address of the fetch |
| fetch_stall | output | 1 | Fetch must wait |
| fetch_data | output | DATA_W | Instruction word, valid when requested and not stalled |
| mem_req | output | 1 | Read request to program memory |
| mem_addr | output | ADDR_W | Read word address |
| mem_ack | input | 1 | Read data valid this cycle |
| mem_rdata | input | DATA_W | Read data from memory |

## Verification
The bench walks one address sequence that fills a sector word by word, brings in a third region after a hit on the older sector, and then revisits the region that was evicted. A cache that evicts by arrival order instead of use would throw out the recently hit region. A cache that keeps stale valid bits after reallocation would return the old region's word for an aliasing address. Memory data carries a generation stamp, so a hit can be told apart from a memory read. This exposes a frozen or disabled cache that still loads words, a disabled cache that still answers hits, and a frozen cache whose replacement order drifts, which shows up as the wrong sector evicted after unfreezing. Miss latencies of zero, one, two and three cycles check that the stall falls exactly in the acknowledge cycle.

// File: rtl/isc_pkg.sv
package isc_pkg;

   localparam int unsigned NSECT = 2;

   // decision taken for the current fetch
   typedef enum logic [2:0] {
      ACT_NONE,
      ACT_HIT,
      ACT_BYPASS,
      ACT_FROZEN_MISS,
      ACT_WORD_FILL,
      ACT_SECT_ALLOC
   } act_e;

endpackage

// File: rtl/isc_sector.sv
module isc_sector #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned TAG_W  = 11,
   parameter int unsigned WORDS  = 32,
   localparam int unsigned IDX_W = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TAG_W-1:0]  lk_tag,
   input  logic [IDX_W-1:0]  lk_idx,
   input  logic              wr_alloc,
   input  logic              wr_fill,
   input  logic [DATA_W-1:0] wr_data,
   output logic              sect_match,
   output logic              word_hit,
   output logic [DATA_W-1:0] rd_data
);

   logic              owned_q;
   logic [TAG_W-1:0]  tag_q;
   logic [WORDS-1:0]  vld_q;
   logic [DATA_W-1:0] word_q [WORDS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owned_q <= 1'b0;
         tag_q   <= '0;
         vld_q   <= '0;
      end else if (wr_alloc) begin
         owned_q <= 1'b1;
         tag_q   <= lk_tag;
         vld_q   <= {{(WORDS-1){1'b0}}, 1'b1} << lk_idx;
      end else if (wr_fill) begin
         vld_q[lk_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_alloc || wr_fill) begin
         word_q[lk_idx] <= wr_data;
      end
   end

   assign sect_match = owned_q && (tag_q == lk_tag);
   assign word_hit   = sect_match && vld_q[lk_idx];
   assign rd_data    = word_q[lk_idx];

   // R5: a freshly allocated sector holds exactly one valid word
   p_alloc_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_alloc |=> ($countones(vld_q) == 1));

   // R4: a word fill adds exactly one new valid word
   p_fill_adds_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_fill && !wr_alloc) |=> ($countones(vld_q) == $past($countones(vld_q)) + 1));

   // R4: writes only ever target a word that missed
   p_write_on_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_alloc || wr_fill) |-> !word_hit);

endmodule

// File: rtl/isc_lru.sv
module isc_lru (
   input  logic clk,
   input  logic rst_n,
   input  logic upd,
   input  logic used,
   output logic victim
);

   logic lru_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lru_q <= 1'b0;
      end else if (upd) begin
         lru_q <= ~used;
      end
   end

   assign victim = lru_q;

endmodule

// File: rtl/isc_ctrl.sv
module isc_ctrl
   import isc_pkg::*;
(
   input  logic             cfg_enable,
   input  logic             cfg_freeze,
   input  logic             fetch_req,
   input  logic             mem_ack,
   input  logic             victim,
   input  logic [NSECT-1:0] sect_match,
   input  logic [NSECT-1:0] word_hit,
   output logic             hit,
   output logic             hit_sel,
   output logic             mem_req,
   output logic             fetch_stall,
   output logic [NSECT-1:0] wr_alloc,
   output logic [NSECT-1:0] wr_fill,
   output logic             lru_upd,
   output logic             lru_used
);

   act_e act;
   logic match_sel;

   assign match_sel = sect_match[1];
   assign hit_sel   = word_hit[1];

   always_comb begin
      act = ACT_NONE;
      if (fetch_req) begin
         if (!cfg_enable)        act = ACT_BYPASS;
         else if (|word_hit)     act = ACT_HIT;
         else if (cfg_freeze)    act = ACT_FROZEN_MISS;
         else if (|sect_match)   act = ACT_WORD_FILL;
         else                    act = ACT_SECT_ALLOC;
      end
   end

   always_comb begin
      hit         = (act == ACT_HIT);
      mem_req     = (act != ACT_NONE) && (act != ACT_HIT);
      fetch_stall = mem_req && !mem_ack;
      wr_alloc    = '0;
      wr_fill     = '0;
      lru_upd     = 1'b0;
      lru_used    = 1'b0;
      case (act)
         ACT_HIT: begin
            lru_upd  = !cfg_freeze;
            lru_used = hit_sel;
         end
         ACT_WORD_FILL: begin
            wr_fill[match_sel] = mem_ack;
            lru_upd            = mem_ack;
            lru_used           = match_sel;
         end
         ACT_SECT_ALLOC: begin
            wr_alloc[victim] = mem_ack;
            lru_upd          = mem_ack;
            lru_used         = victim;
         end
         default: begin
         end
      endcase
   end

endmodule

// File: rtl/isc_cache.sv
module isc_cache
   import isc_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned WORDS  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_enable,
   input  logic              cfg_freeze,
   input  logic              fetch_req,
   input  logic [ADDR_W-1:0] fetch_addr,
   output logic              fetch_stall,
   output logic [DATA_W-1:0] fetch_data,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata
);

   localparam int unsigned IDX_W = $clog2(WORDS);
   localparam int unsigned TAG_W = ADDR_W - IDX_W;

   if ((WORDS < 2) || ((WORDS & (WORDS - 1)) != 0)) begin : g_bad_words
      $error("isc_cache: WORDS must be a power of two of at least 2");
   end
   if (ADDR_W <= IDX_W) begin : g_bad_addr
      $error("isc_cache: ADDR_W must exceed the word index width");
   end

   logic [TAG_W-1:0]  cur_tag;
   logic [IDX_W-1:0]  cur_idx;
   logic [NSECT-1:0]  sect_match;
   logic [NSECT-1:0]  word_hit;
   logic [NSECT-1:0]  wr_alloc;
   logic [NSECT-1:0]  wr_fill;
   logic [DATA_W-1:0] sect_data [NSECT];
   logic              hit;
   logic              hit_sel;
   logic              lru_upd;
   logic              lru_used;
   logic              victim;

   assign cur_tag = fetch_addr[ADDR_W-1:IDX_W];
   assign cur_idx = fetch_addr[IDX_W-1:0];

   for (genvar s = 0; s < NSECT; s++) begin : g_sect
      isc_sector #(
         .DATA_W (DATA_W),
         .TAG_W  (TAG_W),
         .WORDS  (WORDS)
      ) u_sect (
         .clk        (clk),
         .rst_n      (rst_n),
         .lk_tag     (cur_tag),
         .lk_idx     (cur_idx),
         .wr_alloc   (wr_alloc[s]),
         .wr_fill    (wr_fill[s]),
         .wr_data    (mem_rdata),
         .sect_match (sect_match[s]),
         .word_hit   (word_hit[s]),
         .rd_data    (sect_data[s])
      );
   end

   isc_ctrl u_ctrl (
      .cfg_enable  (cfg_enable),
      .cfg_freeze  (cfg_freeze),
      .fetch_req   (fetch_req),
      .mem_ack     (mem_ack),
      .victim      (victim),
      .sect_match  (sect_match),
      .word_hit    (word_hit),
      .hit         (hit),
      .hit_sel     (hit_sel),
      .mem_req     (mem_req),
      .fetch_stall (fetch_stall),
      .wr_alloc    (wr_alloc),
      .wr_fill     (wr_fill),
      .lru_upd     (lru_upd),
      .lru_used    (lru_used)
   );

   isc_lru u_lru (
      .clk    (clk),
      .rst_n  (rst_n),
      .upd    (lru_upd),
      .used   (lru_used),
      .victim (victim)
   );

   assign mem_addr   = fetch_addr;
   assign fetch_data = hit ? sect_data[hit_sel] : mem_rdata;

   // R3: a stall always belongs to an outstanding memory read of the fetch address
   p_stall_owned_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_stall |-> (fetch_req && mem_req && (mem_addr == fetch_addr)));

   // R3: the acknowledge cycle releases the stall with memory data
   p_ack_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack) |-> (!fetch_stall && (fetch_data == mem_rdata)));

   // R2: a valid word in an enabled cache never reaches memory
   p_hit_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && cfg_enable && (|word_hit)) |-> (!mem_req && !fetch_stall));

   // R8: a disabled cache sends every fetch to memory
   p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && !cfg_enable) |-> mem_req);

   // R7: freezing holds the replacement choice
   p_freeze_lru_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_freeze |=> $stable(victim));

   // R5: no region is ever held by both sectors
   p_single_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sect_match));

endmodule

// File: tb/isc_cache_tb_top.sv
module isc_cache_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_enable;
   logic        cfg_freeze;
   logic        fetch_req;
   logic [15:0] fetch_addr;
   logic        fetch_stall;
   logic [31:0] fetch_data;
   logic        mem_req;
   logic [15:0] mem_addr;
   logic        mem_ack;
   logic [31:0] mem_rdata;

   int          checks = 0;
   int          errors = 0;
   bit          done   = 1'b0;
   logic [15:0] gen    = 16'd0;

   always #5 clk = ~clk;

   isc_cache dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_enable  (cfg_enable),
      .cfg_freeze  (cfg_freeze),
      .fetch_req   (fetch_req),
      .fetch_addr  (fetch_addr),
      .fetch_stall (fetch_stall),
      .fetch_data  (fetch_data),
      .mem_req     (mem_req),
      .mem_addr    (mem_addr),
      .mem_ack     (mem_ack),
      .mem_rdata   (mem_rdata)
   );

   function automatic logic [31:0] mem_word(input logic [15:0] a, input logic [15:0] g);
      return {g, a};
   endfunction

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic do_fetch(input logic [15:0] a, input int lat,
                           output logic was_hit, output logic [31:0] d);
      @(negedge clk);
      fetch_req  = 1'b1;
      fetch_addr = a;
      mem_ack    = 1'b0;
      #1;
      if (!mem_req && !fetch_stall) begin
         was_hit = 1'b1;
         d       = fetch_data;
      end else begin
         was_hit = 1'b0;
         for (int i = 0; i < lat; i++) begin
            chk("R3 stall held before ack", {31'd0, fetch_stall}, 32'd1);
            chk("R3 memory address", {16'd0, mem_addr}, {16'd0, a});
            @(negedge clk);
            #1;
         end
         mem_ack   = 1'b1;
         mem_rdata = mem_word(a, gen);
         #1;
         chk("R3 stall low in ack cycle", {31'd0, fetch_stall}, 32'd0);
         d = fetch_data;
      end
      @(posedge clk);
      #1;
      fetch_req = 1'b0;
      mem_ack   = 1'b0;
   endtask

   task automatic want(input string rq, input logic [15:0] a, input int lat,
                       input logic exp_hit, input logic [31:0] exp_d);
      logic        h;
      logic [31:0] d;
      do_fetch(a, lat, h, d);
      chk({rq, " hit flag"}, {31'd0, h}, {31'd0, exp_hit});
      chk({rq, " data"}, d, exp_d);
   endtask

   task automatic t_reset;
      rst_n      = 1'b0;
      cfg_enable = 1'b1;
      cfg_freeze = 1'b0;
      fetch_req  = 1'b0;
      fetch_addr = '0;
      mem_ack    = 1'b0;
      mem_rdata  = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 idle stall", {31'd0, fetch_stall}, 32'd0);
      chk("R1 idle mem_req", {31'd0, mem_req}, 32'd0);
      want("R1 first fetch misses", 16'h0040, 2, 1'b0, mem_word(16'h0040, 16'd0));
   endtask

   task automatic t_fill_and_hit;
      want("R2 refetch hits", 16'h0040, 0, 1'b1, mem_word(16'h0040, 16'd0));
   endtask

   task automatic t_word_fill;
      want("R4 neighbour word misses", 16'h0041, 0, 1'b0, mem_word(16'h0041, 16'd0));
      want("R4 first word kept", 16'h0040, 0, 1'b1, mem_word(16'h0040, 16'd0));
      want("R4 neighbour now hits", 16'h0041, 0, 1'b1, mem_word(16'h0041, 16'd0));
      want("R4 unloaded word misses", 16'h0042, 1, 1'b0, mem_word(16'h0042, 16'd0));
   endtask

   task automatic t_lru_evict;
      want("R5 second region allocs", 16'h0100, 1, 1'b0, mem_word(16'h0100, 16'd0));
      want("R6 touch first region", 16'h0040, 0, 1'b1, mem_word(16'h0040, 16'd0));
      want("R6 third region misses", 16'h0201, 3, 1'b0, mem_word(16'h0201, 16'd0));
      want("R5 stale valid cleared", 16'h0200, 0, 1'b0, mem_word(16'h0200, 16'd0));
      want("R6 recently used survives", 16'h0040, 0, 1'b1, mem_word(16'h0040, 16'd0));
      want("R6 older region evicted", 16'h0100, 1, 1'b0, mem_word(16'h0100, 16'd0));
   endtask

   task automatic t_freeze;
      gen = 16'd1;
      @(negedge clk);
      cfg_freeze = 1'b1;
      want("R7 hit served frozen", 16'h0040, 0, 1'b1, mem_word(16'h0040, 16'd0));
      want("R7 miss served frozen", 16'h0300, 2, 1'b0, mem_word(16'h0300, 16'd1));
      want("R7 frozen miss not loaded", 16'h0300, 0, 1'b0, mem_word(16'h0300, 16'd1));
      @(negedge clk);
      cfg_freeze = 1'b0;
      want("R7 new region after unfreeze", 16'h0400, 1, 1'b0, mem_word(16'h0400, 16'd1));
      want("R7 order held so sector1 kept", 16'h0100, 0, 1'b1, mem_word(16'h0100, 16'd0));
      want("R7 order held so sector0 evicted", 16'h0040, 0, 1'b0, mem_word(16'h0040, 16'd1));
   endtask

   task automatic t_disable;
      gen = 16'd2;
      @(negedge clk);
      cfg_enable = 1'b0;
      want("R8 cached word bypassed", 16'h0040, 1, 1'b0, mem_word(16'h0040, 16'd2));
      want("R8 uncached word bypassed", 16'h0500, 0, 1'b0, mem_word(16'h0500, 16'd2));
      @(negedge clk);
      cfg_enable = 1'b1;
      want("R8 contents kept", 16'h0040, 0, 1'b1, mem_word(16'h0040, 16'd1));
      want("R8 nothing loaded while off", 16'h0500, 0, 1'b0, mem_word(16'h0500, 16'd2));
   endtask

   initial begin
      t_reset;
      t_fill_and_hit;
      t_word_fill;
      t_lru_evict;
      t_freeze;
      t_disable;
      repeat (2) @(posedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog R3 actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule